// File: doc/BRIEF.md
# Fixed-Point Direct-Form IIR Compensator Section

This block evaluates a recursive difference equation for a digital power-converter loop. Each accepted input sample x is combined with up to four earlier inputs and four earlier outputs. The block forms y = a0·x + Σ ai·x[n−i] − Σ bj·y[n−j]. The leading feedback term is implicitly one and is not stored. Coefficients and data are signed 16-bit values in 8.8 fixed point. A single multiplier is used in turn: one product is added to a 40-bit accumulator on each clock. The accumulator has eight guard bits, so partial sums may wrap without harm.

After the last product the sum is rounded and shifted back to 8.8. It is then saturated to a symmetric range. An optional magnitude limit can also be applied, which keeps a pure integrator from running away. The value after clamping is what enters the feedback history. Samples enter and results leave on valid/ready streams. A new sample is taken only when the engine is idle and no result is waiting. A result stays on the output, unchanged, until the consumer takes it. Coefficient writes, the order select, the limit controls, the clear and the overflow flag are plain pins.

Top module: `iir_direct_form`

## Requirements
- R1: The output is round(a0·x + Σi=1..n ai·x[n−i] − Σj=1..n bj·y[n−j]), with all values in 8.8 format (0x0100 = 1.0). Coefficient address k ≤ 4 writes ak, and address 4+j (5..8) writes bj. Writes to addresses 9..15 change nothing. The four input and four output history registers always shift, whatever the order.
- R2: The order input selects n. It is sampled when a sample is accepted. A value of 0 acts as 1, and values above 4 act as 4. out_valid rises 2n+1 clock edges after the accepting edge.
- R3: done is a one-cycle pulse. It is high in exactly the first cycle in which a new result is valid.
- R4: Rounding adds half an LSB and then shifts right arithmetically. So 0.5·3 gives 2 and 0.5·(−3) gives −1.
- R5: Results above 32767 become 32767, and results below −32767 become −32767. The code 0x8000 is never produced.
- R6: When lim_en is high at the last product, the result is clamped to ±lim_mag. The clamped value is the one stored as feedback history.
- R7: ovf goes high on any saturation or limit clamp. It stays high until clr or reset.
- R8: A clr pulse zeroes both histories, drops any result in flight or waiting, and lowers ovf. The coefficients are kept.
- R9: in_ready is high only when idle with no result waiting. While out_valid is high and out_ready is low, out_valid and out_data hold.
- R10: After reset, out_valid, done and ovf are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of histories, flag and pending result |
| order | input | 3 | Requested section order |
| lim_en | input | 1 | Enable magnitude limit |
| lim_mag | input | 15 | Magnitude limit |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient index |
| coef_data | input | 16 | Coefficient value, 8.8 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Engine can accept a sample |
| in_data | input | 16 | Input sample, 8.8 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 16 | Result, 8.8 |
| done | output | 1 | Pulse when a result appears |
| ovf | output | 1 | Sticky clamp flag |

## Verification
The properties assume that coefficient writes and changes to the order or limit pins happen only between calculations. The latency property also expects out_ready to be held steady around the cycle in which a result appears. The stimulus meets both assumptions. It writes coefficients and sets the controls only while the engine is idle with no result waiting. It changes out_ready only at falling edges while a result is held. Test values are kept small enough that the exact sum fits in the accumulator. The reference model can therefore use plain wide integers.

// File: rtl/iir_pkg.sv
package iir_pkg;
  parameter int unsigned IIR_DW        = 16;
  parameter int unsigned IIR_MAX_ORDER = 4;
  parameter int unsigned IIR_FRAC      = 8;
  parameter int unsigned IIR_GUARD     = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MAC  = 1'b1
  } iir_state_e;
endpackage

// File: rtl/iir_coef_bank.sv
module iir_coef_bank #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NCOEF = 9,
  parameter int unsigned AW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [DW-1:0] wr_data,
  output logic signed [DW-1:0] coef [NCOEF]
);
  for (genvar i = 0; i < NCOEF; i++) begin : g_reg
    logic signed [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_addr == AW'(i)) q <= wr_data;
    end
    assign coef[i] = q;
  end
endmodule

// File: rtl/iir_delay_line.sv
module iir_delay_line #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] tap [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic signed [DW-1:0] q;
    logic signed [DW-1:0] nxt;
    if (i == 0) begin : g_head
      assign nxt = din;
    end else begin : g_body
      assign nxt = tap[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (clr) q <= '0;
      else if (push) q <= nxt;
    end
    assign tap[i] = q;
  end
endmodule

// File: rtl/iir_mac.sv
module iir_mac #(
  parameter int unsigned DW    = 16,
  parameter int unsigned ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    first,
  input  logic                    neg,
  input  logic signed [DW-1:0]    coef,
  input  logic signed [DW-1:0]    data,
  output logic signed [ACC_W-1:0] acc_next,
  output logic signed [ACC_W-1:0] acc_q
);
  localparam int unsigned PW = 2 * DW;
  localparam int unsigned GW = ACC_W - PW;

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] term;

  assign prod     = PW'(coef) * PW'(data);
  assign term     = {{GW{prod[PW-1]}}, prod};
  assign acc_next = (first ? '0 : acc_q) + (neg ? -term : term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (en) acc_q <= acc_next;
  end
endmodule

// File: rtl/iir_limiter.sv
module iir_limiter #(
  parameter int unsigned DW    = 16,
  parameter int unsigned ACC_W = 40,
  parameter int unsigned FRAC  = 8
) (
  input  logic signed [ACC_W-1:0] acc,
  input  logic                    lim_en,
  input  logic [DW-2:0]           lim_mag,
  output logic signed [DW-1:0]    y,
  output logic                    hit
);
  localparam logic signed [ACC_W-1:0] POS_MAX = ACC_W'((64'(1) << (DW - 1)) - 64'(1));
  localparam logic signed [ACC_W-1:0] NEG_MAX = -POS_MAX;

  logic signed [ACC_W-1:0] rounded;
  logic signed [ACC_W-1:0] sat_v;
  logic signed [ACC_W-1:0] lim_v;
  logic signed [ACC_W-1:0] lim_pos;
  logic                    sat_hit;
  logic                    lim_hit;

  if (FRAC == 0) begin : g_noround
    assign rounded = acc;
  end else begin : g_round
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'(1) << (FRAC - 1));
    assign rounded = (acc + HALF) >>> FRAC;
  end

  assign lim_pos = ACC_W'({1'b0, lim_mag});

  always_comb begin
    sat_hit = 1'b0;
    sat_v   = rounded;
    if (rounded > POS_MAX) begin
      sat_v   = POS_MAX;
      sat_hit = 1'b1;
    end else if (rounded < NEG_MAX) begin
      sat_v   = NEG_MAX;
      sat_hit = 1'b1;
    end
    lim_hit = 1'b0;
    lim_v   = sat_v;
    if (lim_en) begin
      if (sat_v > lim_pos) begin
        lim_v   = lim_pos;
        lim_hit = 1'b1;
      end else if (sat_v < -lim_pos) begin
        lim_v   = -lim_pos;
        lim_hit = 1'b1;
      end
    end
  end

  assign y   = lim_v[DW-1:0];
  assign hit = sat_hit | lim_hit;
endmodule

// File: rtl/iir_direct_form.sv
module iir_direct_form
  import iir_pkg::*;
#(
  parameter int unsigned DW        = IIR_DW,
  parameter int unsigned MAX_ORDER = IIR_MAX_ORDER,
  parameter int unsigned FRAC      = IIR_FRAC,
  parameter int unsigned GUARD     = IIR_GUARD,
  localparam int unsigned NCOEF    = 2 * MAX_ORDER + 1,
  localparam int unsigned AW       = $clog2(NCOEF),
  localparam int unsigned OW       = $clog2(MAX_ORDER + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [OW-1:0]        order,
  input  logic                 lim_en,
  input  logic [DW-2:0]        lim_mag,
  input  logic                 coef_wr,
  input  logic [AW-1:0]        coef_addr,
  input  logic signed [DW-1:0] coef_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data,
  output logic                 done,
  output logic                 ovf
);
  localparam int unsigned ACC_W = 2 * DW + GUARD;
  localparam int unsigned IW    = AW;

  iir_state_e           state;
  logic [IW-1:0]        idx;
  logic [OW-1:0]        n_q;
  logic [OW-1:0]        ord_eff;
  logic [IW-1:0]        last_idx;
  logic signed [DW-1:0] x_cur;
  logic signed [DW-1:0] cf [NCOEF];
  logic signed [DW-1:0] xt [MAX_ORDER];
  logic signed [DW-1:0] yt [MAX_ORDER];
  logic signed [DW-1:0] op_c;
  logic signed [DW-1:0] op_d;
  logic                 op_neg;
  logic                 mac_en;
  logic                 last;
  logic                 accept;
  logic signed [ACC_W-1:0] acc_next;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [DW-1:0] y_new;
  logic                 hit;

  iir_coef_bank #(.DW(DW), .NCOEF(NCOEF), .AW(AW)) u_coef (
    .clk, .rst_n, .wr_en(coef_wr), .wr_addr(coef_addr), .wr_data(coef_data), .coef(cf)
  );

  iir_delay_line #(.DW(DW), .DEPTH(MAX_ORDER)) u_xhist (
    .clk, .rst_n, .clr, .push(last), .din(x_cur), .tap(xt)
  );

  iir_delay_line #(.DW(DW), .DEPTH(MAX_ORDER)) u_yhist (
    .clk, .rst_n, .clr, .push(last), .din(y_new), .tap(yt)
  );

  iir_mac #(.DW(DW), .ACC_W(ACC_W)) u_mac (
    .clk, .rst_n, .en(mac_en), .first(idx == '0), .neg(op_neg),
    .coef(op_c), .data(op_d), .acc_next, .acc_q
  );

  iir_limiter #(.DW(DW), .ACC_W(ACC_W), .FRAC(FRAC)) u_lim (
    .acc(acc_next), .lim_en, .lim_mag, .y(y_new), .hit
  );

  always_comb begin
    if (order == '0) ord_eff = OW'(1);
    else if (int'(order) > int'(MAX_ORDER)) ord_eff = OW'(MAX_ORDER);
    else ord_eff = order;
  end

  assign last_idx = IW'(2 * int'(n_q));
  assign in_ready = (state == ST_IDLE) && !out_valid;
  assign accept   = in_valid && in_ready;
  assign mac_en   = (state == ST_MAC) && !clr;
  assign last     = mac_en && (idx == last_idx);

  always_comb begin
    op_c   = '0;
    op_d   = '0;
    op_neg = 1'b0;
    if (idx == '0) begin
      op_c = cf[0];
      op_d = x_cur;
    end
    for (int i = 1; i <= int'(MAX_ORDER); i++) begin
      if (i <= int'(n_q)) begin
        if (int'(idx) == i) begin
          op_c = cf[i];
          op_d = xt[i-1];
        end
        if (int'(idx) == int'(n_q) + i) begin
          op_c   = cf[int'(MAX_ORDER) + i];
          op_d   = yt[i-1];
          op_neg = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      n_q       <= OW'(1);
      x_cur     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
      ovf       <= 1'b0;
    end else if (clr) begin
      state     <= ST_IDLE;
      idx       <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            x_cur <= in_data;
            n_q   <= ord_eff;
            idx   <= '0;
            state <= ST_MAC;
          end
        end
        ST_MAC: begin
          if (last) begin
            out_data  <= y_new;
            out_valid <= 1'b1;
            done      <= 1'b1;
            if (hit) ovf <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iir_direct_form_chk.sv
module iir_direct_form_chk #(
  parameter int unsigned DW        = 16,
  parameter int unsigned MAX_ORDER = 4,
  localparam int unsigned OW       = $clog2(MAX_ORDER + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic [OW-1:0]        order,
  input logic                 lim_en,
  input logic [DW-2:0]        lim_mag,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_data,
  input logic                 done,
  input logic                 ovf
);
  logic [7:0] cyc;
  logic [7:0] exp_lat;
  int         eff;

  always_comb begin
    eff = int'(order);
    if (eff < 1) eff = 1;
    if (eff > int'(MAX_ORDER)) eff = int'(MAX_ORDER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc     <= '0;
      exp_lat <= '0;
    end else if (in_valid && in_ready) begin
      cyc     <= '0;
      exp_lat <= 8'(2 * eff + 1);
    end else if (cyc != 8'hFF) begin
      cyc <= cyc + 8'd1;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> cyc == exp_lat); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) done |-> out_valid && !$past(out_valid)); // R3
  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_data != {1'b1, {(DW-1){1'b0}}}); // R5
  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(lim_en)) |-> (out_data <= $signed({1'b0, $past(lim_mag)})) && (out_data >= -$signed({1'b0, $past(lim_mag)}))); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf && !clr) |=> ovf); // R7
  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n) clr |=> !out_valid && !ovf && !done); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && !clr) |=> !in_ready); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> out_valid && $stable(out_data)); // R9
endmodule

bind iir_direct_form iir_direct_form_chk #(.DW(DW), .MAX_ORDER(MAX_ORDER)) u_chk (.*);

// File: tb/sim_iir_direct_form.sv
module sim_iir_direct_form;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               clr = 1'b0;
  logic [2:0]         order = 3'd1;
  logic               lim_en = 1'b0;
  logic [14:0]        lim_mag = '0;
  logic               coef_wr = 1'b0;
  logic [3:0]         coef_addr = '0;
  logic signed [15:0] coef_data = '0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [15:0] in_data = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic signed [15:0] out_data;
  logic               done;
  logic               ovf;

  int total = 0;
  int failed = 0;
  int cf [9];
  int xq[$];
  int yq[$];
  bit m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iir_direct_form u0 (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_order(input int o);
    if (o < 1) return 1;
    if (o > 4) return 4;
    return o;
  endfunction

  function automatic int model_step(input int x, input int o);
    longint s;
    longint r;
    int n = eff_order(o);
    s = longint'(cf[0]) * x;
    for (int i = 1; i <= n; i++) s += longint'(cf[i]) * xq[i-1];
    for (int j = 1; j <= n; j++) s -= longint'(cf[4+j]) * yq[j-1];
    r = (s + 128) >>> 8;
    if (r > 32767) begin r = 32767; m_ovf = 1; end
    if (r < -32767) begin r = -32767; m_ovf = 1; end
    if (lim_en) begin
      if (r > longint'(lim_mag)) begin r = lim_mag; m_ovf = 1; end
      if (r < -longint'(lim_mag)) begin r = -longint'(lim_mag); m_ovf = 1; end
    end
    xq.push_front(x); void'(xq.pop_back());
    yq.push_front(int'(r)); void'(yq.pop_back());
    return int'(r);
  endfunction

  task automatic model_clear();
    xq = '{0, 0, 0, 0};
    yq = '{0, 0, 0, 0};
    m_ovf = 0;
  endtask

  task automatic wcoef(input int addr, input int val);
    @(negedge clk);
    coef_wr = 1'b1; coef_addr = 4'(addr); coef_data = 16'(val);
    @(negedge clk);
    coef_wr = 1'b0;
    if (addr <= 8) cf[addr] = val;
  endtask

  task automatic zero_coefs();
    for (int k = 0; k < 9; k++) wcoef(k, 0);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_clear();
    chk("R8 out_valid after clr", out_valid, 0);
    chk("R8 ovf after clr", ovf, 0);
  endtask

  // send one sample; returns output seen; checks latency (R2), done (R3), value (R1)
  task automatic send(input int x, input int o, input string req, output int got);
    int lat;
    int expv;
    @(negedge clk);
    order = 3'(o); in_data = 16'(x); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    expv = model_step(x, o);
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R2 latency", lat, 2 * eff_order(o) + 1);
    chk("R3 done with result", done, 1);
    chk(req, out_data, expv);
    got = out_data;
    chk("R7 ovf", ovf, m_ovf);
    if (out_ready) begin
      @(negedge clk);
      chk("R3 done one cycle", done, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failed++; total++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int g;
    for (int k = 0; k < 9; k++) cf[k] = 0;
    model_clear();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", out_valid, 0);
    chk("R10 done", done, 0);
    chk("R10 ovf", ovf, 0);
    chk("R10 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 in_ready after release", in_ready, 1);

    // R1 pass-through a0=1.0
    wcoef(0, 16'sh0100);
    send(1234, 1, "R1 unity", g);
    send(-517, 1, "R1 unity neg", g);
    chk("R1 unity value", g, -517);

    // R1 first-order low pass: a0=0.25, b1=-0.75
    do_clear();
    wcoef(0, 64); wcoef(5, -192);
    for (int k = 0; k < 6; k++) send(1000, 1, "R1 lowpass step", g);

    // R1 fourth-order mix, R2 order clamp
    do_clear();
    wcoef(0, 100); wcoef(1, -50); wcoef(2, 30); wcoef(3, 20); wcoef(4, -10);
    wcoef(5, 40); wcoef(6, -20); wcoef(7, 10); wcoef(8, 5);
    wcoef(12, 999);  // R1 out-of-range address ignored
    send(800, 4, "R1 order4", g);
    send(-300, 4, "R1 order4", g);
    send(500, 7, "R2 order 7 as 4", g);
    send(250, 0, "R2 order 0 as 1", g);
    send(-900, 2, "R1 order2", g);
    send(60, 3, "R1 order3", g);

    // R4 rounding
    do_clear();
    zero_coefs();
    wcoef(0, 128);
    send(3, 1, "R4 round up", g);
    chk("R4 0.5*3", g, 2);
    send(-3, 1, "R4 round neg", g);
    chk("R4 0.5*-3", g, -1);

    // R5 saturation, R7 flag
    do_clear();
    wcoef(0, 16'sh7FFF);
    send(1000, 1, "R5 sat pos", g);
    chk("R5 positive max", g, 32767);
    send(-1000, 1, "R5 sat neg", g);
    chk("R5 negative max", g, -32767);
    chk("R7 ovf sticky", ovf, 1);
    send(0, 1, "R7 zero input", g);
    chk("R7 ovf still set", ovf, 1);

    // R6 integrator with limit
    do_clear();
    zero_coefs();
    wcoef(0, 256); wcoef(5, -256);
    lim_en = 1'b1; lim_mag = 15'd5000;
    for (int k = 0; k < 4; k++) send(1000, 1, "R6 integrate", g);
    chk("R7 no clamp yet", ovf, 0);
    for (int k = 0; k < 3; k++) send(1000, 1, "R6 integrate clamp", g);
    chk("R6 limit value", g, 5000);
    send(-2000, 1, "R6 feedback from clamped", g);
    chk("R6 stored clamp", g, 3000);
    lim_en = 1'b0;

    // R8 clear zeroes history
    do_clear();
    send(100, 1, "R8 history zero", g);
    chk("R8 after clear", g, 100);

    // R9 back-pressure
    out_ready = 1'b0;
    send(200, 1, "R9 held result", g);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 valid held", out_valid, 1);
      chk("R9 data stable", out_data, 300);
      chk("R9 no accept", in_ready, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", out_valid, 0);
    chk("R9 ready again", in_ready, 1);

    // R8 clr drops waiting result
    out_ready = 1'b0;
    send(5, 1, "R8 pending", g);
    out_ready = 1'b1;
    do_clear();
    chk("R8 no stale result", out_valid, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule